// File: doc/BRIEF.md
# Indexed Block-Access Serial Register Target

This block is a target on a two-wire serial management bus. It gives a host indexed block writes and block reads into a small byte-addressed register bank. The clock and data lines arrive as open-drain signals. The block samples each line on its own input and pulls the data line low through a separate drive-enable output. Both inputs pass through two-flop synchronisers into the system clock. Bus edges, START and STOP are then detected from the synchronised values.

A write names a starting index and then a byte count. The data bytes that follow are stored at consecutive indexes, and each byte the count allows is acknowledged. A read first sets the index with a short write and then turns the bus around with a repeated START. The target returns a count byte, then that many data bytes. The read length comes from a 5-bit count register that the target keeps at index 7, not from the host's final NACK. The remaining indexes sit in an external bank, reached through a combinational read port and a one-cycle write strobe.

Top module: `smb_blk_target`

## Requirements
- R1: After reset the data line is released (sda_oe=0), reg_we is low and the count register holds 8.
- R2: An address byte whose upper seven bits equal 6Ch (write form D8h, read form D9h) is acknowledged. Any other address is NACKed, and every later byte is NACKed and ignored until the next START.
- R3: A write is address with bit0=0, index N, count X, then data. The first X data bytes are acknowledged and written to N, N+1, ... Each write is a single-cycle reg_we pulse with reg_waddr and reg_wdata.
- R4: A data byte beyond the count X is NACKed and is not written.
- R5: After a repeated START with address bit0=1, the target first sends a count byte. It then sends data from index N upward, taking each index from reg_raddr/reg_rdata.
- R6: Index 7 is the count register: 5 bits, reset value 8, writable and readable through the bus. Its value is the count byte, and the target sends exactly that many data bytes. Beyond that it leaves SDA released, so the host reads FFh.
- R7: Read indexes above 8 return 00h. Write indexes above 8 are acknowledged but produce no reg_we.
- R8: A host NACK after a read byte ends the transfer. The target keeps SDA released until the next START or STOP.
- R9: A STOP in the middle of a byte returns the target to idle, and a START in the middle of a byte returns it to address reception. Neither writes the partial byte.
- R10: The target changes its SDA drive only while SCL is low, and it samples SDA on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_raddr | output | 8 | Current index presented to the bank |
| reg_rdata | input | 8 | Bank data for reg_raddr |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_waddr | output | 8 | Index being written |
| reg_wdata | output | 8 | Byte being written |

## Verification
One detected falling SCL edge does two jobs at once. It commits the received data byte, either as a bank strobe or as an update of the count register. It also decides, from the remaining count, whether the byte is acknowledged. The bench sweeps every start index with several counts, so that writes end exactly where the count runs out. Some of these writes have their last byte land on the count register itself, and others send bytes past the count. Each case is judged by the acknowledge bit, the number of strobes and a complete read-back, all against an arithmetic model kept in the bench.

// File: rtl/smb_blk_target.sv
module smb_blk_target #(
  parameter logic [6:0] ADDR7    = 7'h6C,
  parameter int         NUM_REGS = 9,
  parameter int         CNT_IDX  = 7,
  parameter int         CNT_W    = 5,
  parameter int         CNT_RST  = 8,
  parameter int         IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [IDX_W-1:0] reg_raddr,
  input  logic [7:0]       reg_rdata,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_waddr,
  output logic [7:0]       reg_wdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] CIDX = IDX_W'(CNT_IDX);

  typedef enum logic [2:0] {IDLE, RX, ACK, TX, HACK, DROP} st_t;
  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_t;

  logic [2:0]       scl_q, sda_q;
  st_t              st;
  kind_t            kind;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wrem;
  logic [CNT_W-1:0] rrem, cnt;
  logic             rd_go, host_ack;

  logic s_scl, p_scl, s_sda, p_sda;
  logic scl_rise, scl_fall, start_det, stop_det, quiet;
  logic [7:0] cnt_byte, rd_val, nxt_byte;

  assign s_scl = scl_q[1];
  assign p_scl = scl_q[2];
  assign s_sda = sda_q[1];
  assign p_sda = sda_q[2];
  assign scl_rise  = s_scl & ~p_scl;
  assign scl_fall  = ~s_scl & p_scl;
  assign start_det = s_scl & p_scl & p_sda & ~s_sda;
  assign stop_det  = s_scl & p_scl & ~p_sda & s_sda;
  assign quiet     = (st == IDLE) || (st == DROP);

  assign reg_raddr = idx;
  assign cnt_byte  = {{(8-CNT_W){1'b0}}, cnt};
  assign rd_val    = (idx == CIDX) ? cnt_byte : ((idx <= LAST) ? reg_rdata : 8'h00);
  assign nxt_byte  = (rrem != '0) ? rd_val : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      kind      <= K_ADDR;
      bitcnt    <= '0;
      sh        <= '0;
      idx       <= '0;
      wrem      <= '0;
      rrem      <= '0;
      cnt       <= CNT_W'(CNT_RST);
      rd_go     <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], s_sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == ADDR7) begin
                    sda_oe <= 1'b1;
                    st     <= ACK;
                    rd_go  <= sh[0];
                    kind   <= K_IDX;
                  end else begin
                    st <= DROP;
                  end
                end
                K_IDX: begin
                  idx    <= sh[IDX_W-1:0];
                  kind   <= K_CNT;
                  sda_oe <= 1'b1;
                  st     <= ACK;
                end
                K_CNT: begin
                  wrem   <= sh;
                  kind   <= K_DATA;
                  sda_oe <= 1'b1;
                  st     <= ACK;
                end
                default: begin
                  if (wrem != 8'd0) begin
                    sda_oe <= 1'b1;
                    st     <= ACK;
                    wrem   <= wrem - 8'd1;
                    idx    <= idx + 1'b1;
                    if (idx == CIDX) begin
                      cnt <= sh[CNT_W-1:0];
                    end else if (idx <= LAST) begin
                      reg_we    <= 1'b1;
                      reg_waddr <= idx;
                      reg_wdata <= sh;
                    end
                  end else begin
                    st <= DROP;
                  end
                end
              endcase
            end
          end
          ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_go) begin
                rd_go  <= 1'b0;
                st     <= TX;
                sh     <= cnt_byte;
                rrem   <= cnt;
                sda_oe <= ~cnt_byte[7];
              end else begin
                st     <= RX;
                sda_oe <= 1'b0;
              end
            end
          end
          TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= HACK;
              end else begin
                sh     <= {sh[6:0], 1'b1};
                sda_oe <= ~sh[6];
              end
            end
          end
          HACK: begin
            if (scl_rise) begin
              host_ack <= ~s_sda;
            end else if (scl_fall) begin
              if (host_ack) begin
                sh     <= nxt_byte;
                sda_oe <= ~nxt_byte[7];
                bitcnt <= '0;
                st     <= TX;
                if (rrem != '0) begin
                  rrem <= rrem - 1'b1;
                  idx  <= idx + 1'b1;
                end
              end else begin
                st <= DROP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module smb_blk_target_chk #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 9,
  parameter int CNT_IDX  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_scl,
  input logic             stop_det,
  input logic             quiet,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_waddr
);
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !$past(s_scl));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r7_strobe_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_waddr < IDX_W'(NUM_REGS) && reg_waddr != IDX_W'(CNT_IDX)));
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r8_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe);
endmodule

bind smb_blk_target smb_blk_target_chk #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX)) u_chk (.*);

// File: tb/sim_smb_blk_target.sv
module sim_smb_blk_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b1;
  logic h_low = 1'b0;
  wire  sda_bus;
  logic sda_oe, reg_we;
  logic [7:0] reg_raddr, reg_waddr, reg_wdata, reg_rdata;
  logic [7:0] mem [0:15];
  logic [7:0] exp_m [0:8];
  logic [4:0] exp_cnt;
  int n_chk = 0, n_bad = 0, we_cnt = 0;
  logic done = 1'b0, oe_seen = 1'b0, r10_bad = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = ~(h_low | sda_oe);

  smb_blk_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata));

  assign reg_rdata = (reg_raddr == 8'd7) ? 8'h55 :
                     (reg_raddr < 8'd16) ? mem[reg_raddr[3:0]] : 8'hAA;

  logic oe_d = 1'b0;
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_waddr[3:0]] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (sda_oe) oe_seen <= 1'b1;
    if (sda_oe != oe_d && h_scl) r10_bad <= 1'b1;
    oe_d <= sda_oe;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    waitc(4); h_low = ~b; waitc(4); h_scl = 1'b1; waitc(8); h_scl = 1'b0;
  endtask

  task automatic bit_r(output logic b);
    waitc(4); h_low = 1'b0; waitc(4); h_scl = 1'b1; waitc(5); b = sda_bus; waitc(3); h_scl = 1'b0;
  endtask

  task automatic start_c;
    waitc(4); h_low = 1'b0; waitc(4); h_scl = 1'b1; waitc(8); h_low = 1'b1; waitc(8); h_scl = 1'b0;
  endtask

  task automatic stop_c;
    waitc(4); h_low = 1'b1; waitc(4); h_scl = 1'b1; waitc(8); h_low = 1'b0; waitc(8);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(x);
    ack = ~x;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_r(x); b[i] = x; end
    bit_w(~ack);
  endtask

  function automatic logic [7:0] dgen(input int n, input int k, input int seed);
    return 8'((n * 37 + k * 11 + seed * 5 + 3) & 255);
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    if (i == 7) return {3'b000, exp_cnt};
    if (i < 9) return exp_m[i];
    return 8'h00;
  endfunction

  task automatic blk_write(input int n, input int x, input int sent, input int seed);
    logic a;
    int we0, ewe;
    logic hi;
    we0 = we_cnt; ewe = 0; hi = 1'b0;
    start_c;
    wbyte(8'hD8, a); chk(a, 1, "R2 address ack");
    wbyte(8'(n), a); chk(a, 1, "R3 index ack");
    wbyte(8'(x), a); chk(a, 1, "R3 count ack");
    for (int k = 0; k < sent; k++) begin
      wbyte(dgen(n, k, seed), a);
      if (k < x) begin
        chk(a, 1, "R3 data ack");
        if (n + k == 7) exp_cnt = dgen(n, k, seed) & 8'h1F;
        else if (n + k < 9) begin exp_m[n + k] = dgen(n, k, seed); ewe++; end
        else hi = 1'b1;
      end else begin
        chk(a, 0, "R4 byte past count NACKed");
      end
    end
    stop_c;
    if (hi) chk(we_cnt - we0, ewe, "R7 strobe count");
    else    chk(we_cnt - we0, ewe, "R3 strobe count");
  endtask

  task automatic blk_read(input int n, input int stop_after);
    logic a;
    logic [7:0] b;
    int tot;
    start_c;
    wbyte(8'hD8, a); chk(a, 1, "R2 address ack");
    wbyte(8'(n), a); chk(a, 1, "R5 index ack");
    start_c;
    wbyte(8'hD9, a); chk(a, 1, "R5 read address ack");
    tot = (stop_after >= 0) ? stop_after : exp_cnt + 2;
    rbyte(b, tot > 0); chk(b, {3'b000, exp_cnt}, "R6 count byte");
    for (int k = 0; k < tot; k++) begin
      rbyte(b, k != tot - 1);
      if (k < exp_cnt) begin
        if (n + k >= 9) chk(b, 8'h00, "R7 read past end");
        else chk(b, exp_rd(n + k), "R5 read data");
      end else begin
        chk(b, 8'hFF, "R6 released after count");
      end
    end
    if (stop_after >= 0) begin
      oe_seen = 1'b0;
      rbyte(b, 1'b0);
      chk(oe_seen, 0, "R8 released after host NACK");
      chk(b, 8'hFF, "R8 idle byte");
    end
    stop_c;
  endtask

  initial begin
    logic a;
    int we0;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);
    for (int i = 0; i < 9; i++) exp_m[i] = (i == 7) ? 8'h00 : 8'(i * 17);
    exp_cnt = 5'd8;
    waitc(10);
    chk(sda_oe, 0, "R1 reset drive");
    chk(reg_we, 0, "R1 reset strobe");
    rst_n = 1'b1;
    waitc(10);
    blk_read(0, -1);

    we0 = we_cnt;
    start_c;
    wbyte(8'hDA, a); chk(a, 0, "R2 foreign address NACK");
    wbyte(8'h00, a); chk(a, 0, "R2 ignored after mismatch");
    wbyte(8'h01, a); chk(a, 0, "R2 ignored after mismatch");
    wbyte(8'h77, a); chk(a, 0, "R2 ignored after mismatch");
    stop_c;
    chk(we_cnt - we0, 0, "R2 no strobe");

    for (int n = 0; n < 9; n++) begin
      for (int x = 1; x <= 4 && n + x <= 9; x++) blk_write(n, x, x, n * 4 + x);
      blk_read(n, -1);
    end

    blk_write(2, 2, 4, 50);
    blk_read(0, -1);

    blk_write(7, 1, 1, 0);
    exp_cnt = 5'd3;
    start_c; wbyte(8'hD8, a); wbyte(8'd7, a); wbyte(8'd1, a); wbyte(8'h03, a);
    chk(a, 1, "R6 count write ack"); stop_c;
    blk_read(0, -1);
    start_c; wbyte(8'hD8, a); wbyte(8'd7, a); wbyte(8'd1, a); wbyte(8'h05, a); stop_c;
    exp_cnt = 5'd5;
    blk_read(6, -1);

    blk_write(9, 3, 3, 9);
    blk_write(7, 4, 4, 11);
    blk_read(0, -1);

    start_c; wbyte(8'hD8, a); wbyte(8'd0, a); wbyte(8'd31, a); stop_c;
    if (exp_cnt < 3) begin
      start_c; wbyte(8'hD8, a); wbyte(8'd7, a); wbyte(8'd1, a); wbyte(8'h06, a); stop_c;
      exp_cnt = 5'd6;
    end
    blk_read(1, 2);

    we0 = we_cnt;
    start_c; wbyte(8'hD8, a); wbyte(8'd0, a); wbyte(8'd1, a);
    for (int i = 0; i < 4; i++) bit_w(1'b0);
    stop_c;
    chk(we_cnt - we0, 0, "R9 STOP mid-byte no write");
    blk_read(0, -1);

    we0 = we_cnt;
    start_c; wbyte(8'hD8, a); wbyte(8'd1, a); wbyte(8'd1, a);
    for (int i = 0; i < 3; i++) bit_w(1'b1);
    start_c;
    wbyte(8'hD8, a); chk(a, 1, "R9 address after START mid-byte");
    wbyte(8'd2, a); wbyte(8'd1, a); wbyte(8'h3C, a); chk(a, 1, "R9 data after restart");
    stop_c;
    exp_m[2] = 8'h3C;
    chk(we_cnt - we0, 1, "R9 one strobe only");
    blk_read(0, -1);

    chk(r10_bad, 0, "R10 drive changed while SCL high");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule